// File: doc/BRIEF.md
# Large-Frame Transmit Bit Serializer

This block serializes the data portion of one transmit frame whose length lies between 4 and 16 bits. The frame arrives as two byte-wide buffer elements: the low element carries frame bits 7..0, the high element carries any bits above bit 7. A load handshake (`load_valid` / `load_ready`) hands over both elements together with the frame length and the bit-order selection. All of these are captured in one cycle and are not read again until the frame is finished.

The block puts one data bit on `tx_bit` per bit period. It moves to the next bit only when the external `bit_tick` strobe is high, so the same block serves both an asynchronous and a clocked link. When the last bit has lasted one full tick period, a one-cycle `done` pulse follows, and the block accepts a new frame in the next cycle. Framing bits, parity, baud timing and queuing belong to neighbouring blocks.

The controller has three states. `ST_IDLE` is ready and drives the line high. It goes to `ST_SHIFT` on an accepted load. `ST_SHIFT` presents data bits. It goes to `ST_FINISH` on a tick while the final bit is on the line. `ST_FINISH` raises `done` for one cycle and returns unconditionally to `ST_IDLE`.

Top module: `frame_bit_serializer`

## Requirements
- R1: After reset, and whenever no frame is in progress, `load_ready`=1, `busy`=0, `done`=0 and `tx_bit`=1.
- R2: With `msb_first`=0, bits go out low element bit 0 up to bit 7, then high element bit 0 upward, for a total of exactly the frame length. A frame of 8 bits or fewer uses only the low element, bits 0 up to length-1.
- R3: With `msb_first`=1 and a length of 10 to 16, the bits go out in this order: high element bit (length-9) down to high element bit 0, then low element bit 7 down to bit 0.
- R4: With `msb_first`=1 and a length below 10, only the low element is sent. For a length of 9 this is bits 7 down to 0, which is 8 bits. For a length of 8 or less it is bits (length-1) down to 0.
- R5: `tx_bit` changes only in the cycle after a cycle in which `bit_tick`=1. Without a tick, the current bit holds indefinitely.
- R6: In the cycle after a handshake (`load_valid`=1 while `load_ready`=1), `busy`=1, `load_ready`=0 and the first frame bit is on `tx_bit`.
- R7: In the cycle after the tick that ends the last bit, `done`=1 for exactly one cycle. In the following cycle `load_ready`=1 and `busy`=0.
- R8: While `busy`=1, the element inputs, `frame_len`, `msb_first` and `load_valid` have no effect on the bits sent or on their count.
- R9: A `frame_len` value below 4 is treated as 4. A value above 16 is treated as 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| load_valid | input | 1 | Frame offered for loading |
| load_ready | output | 1 | Block can accept a frame |
| elem_lo | input | 8 | Low buffer element, frame bits 7..0 |
| elem_hi | input | 8 | High buffer element, frame bits 15..8 (upper bits unused for short frames) |
| frame_len | input | 5 | Frame length in bits, 4 to 16 (clamped) |
| msb_first | input | 1 | 1 = most significant bit first, 0 = least significant bit first |
| bit_tick | input | 1 | Bit-period strobe; advances to the next bit |
| tx_bit | output | 1 | Current data bit, 1 when idle |
| busy | output | 1 | Frame in progress (shifting or finishing) |
| done | output | 1 | One-cycle pulse after the last bit period |

## Verification
A wrong start index or step direction shows up as a wrong value on `tx_bit` in the first cycle after the load, or at the first tick. A wrong remaining-bit count shows up as `done` arriving one or more ticks too early or too late. A controller stuck in `ST_FINISH` or `ST_SHIFT` leaves `load_ready` low in the cycle where R7 requires it high. A frame whose inputs are not captured, or are captured again while busy, shows up as a wrong bit at the next tick after the inputs are disturbed.

// File: rtl/fbs_pkg.sv
package fbs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SHIFT  = 2'd1,
        ST_FINISH = 2'd2
    } fbs_state_e;
endpackage

// File: rtl/fbs_order_plan.sv
// Works out, from the requested length and order, where the walk starts,
// how many steps follow the first bit, and which way the index moves.
module fbs_order_plan #(
    parameter int DATA_W  = 16,
    parameter int ELEM_W  = 8,
    parameter int MIN_LEN = 4,
    parameter int LEN_W   = 5,
    parameter int IDX_W   = 4
) (
    input  logic [LEN_W-1:0] frame_len,
    input  logic             msb_first,
    output logic [IDX_W-1:0] start_idx,
    output logic [LEN_W-1:0] span,
    output logic             step_down
);
    logic [LEN_W-1:0] len_c;

    // R9: clamp the length into the legal window
    always_comb begin
        if (frame_len < LEN_W'(MIN_LEN))
            len_c = LEN_W'(MIN_LEN);
        else if (frame_len > LEN_W'(DATA_W))
            len_c = LEN_W'(DATA_W);
        else
            len_c = frame_len;
    end

    always_comb begin
        step_down = msb_first;
        if (!msb_first) begin
            start_idx = '0;
            span      = len_c - LEN_W'(1);
        end else if (len_c == LEN_W'(ELEM_W + 1)) begin
            // R4: one bit past an element sends the low element alone
            start_idx = IDX_W'(ELEM_W - 1);
            span      = LEN_W'(ELEM_W - 1);
        end else begin
            start_idx = IDX_W'(len_c - LEN_W'(1));
            span      = len_c - LEN_W'(1);
        end
    end
endmodule

// File: rtl/fbs_bit_walker.sv
// Bit index and remaining-step counter; steps on each accepted tick.
module fbs_bit_walker #(
    parameter int LEN_W = 5,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             advance,
    input  logic [IDX_W-1:0] start_idx,
    input  logic [LEN_W-1:0] span,
    input  logic             step_down,
    output logic [IDX_W-1:0] idx,
    output logic             last
);
    logic [IDX_W-1:0] idx_q;
    logic [LEN_W-1:0] rem_q;
    logic             down_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q  <= '0;
            rem_q  <= '0;
            down_q <= 1'b0;
        end else if (load) begin
            idx_q  <= start_idx;
            rem_q  <= span;
            down_q <= step_down;
        end else if (advance && (rem_q != '0)) begin
            idx_q  <= down_q ? (idx_q - IDX_W'(1)) : (idx_q + IDX_W'(1));
            rem_q  <= rem_q - LEN_W'(1);
        end
    end

    assign idx  = idx_q;
    assign last = (rem_q == '0);

    // R5: each accepted step moves the index by exactly one position
    a_r5_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !load && (rem_q != '0)) |=>
            ((idx_q == IDX_W'($past(idx_q) + IDX_W'(1))) ||
             (idx_q == IDX_W'($past(idx_q) - IDX_W'(1)))));

    // R5: no tick, no movement
    a_r5_walker_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!advance && !load) |=> $stable(idx_q) && $stable(rem_q));
endmodule

// File: rtl/fbs_frame_hold.sv
// Holds the buffer elements for the duration of a frame; selects one bit.
module fbs_frame_hold #(
    parameter int DATA_W = 16,
    parameter int ELEM_W = 8,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [DATA_W-1:0] frame_in,
    input  logic [IDX_W-1:0]  sel,
    output logic              bit_out
);
    localparam int ELEMS = DATA_W / ELEM_W;

    logic [DATA_W-1:0] held;

    for (genvar e = 0; e < ELEMS; e++) begin : g_elem
        logic [ELEM_W-1:0] q;
        always_ff @(posedge clk) begin
            if (!rst_n)
                q <= '0;
            else if (capture)
                q <= frame_in[e*ELEM_W +: ELEM_W];
        end
        assign held[e*ELEM_W +: ELEM_W] = q;
    end

    assign bit_out = held[sel];

    // R8: the held frame changes only when a capture is requested
    a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> $stable(held));
endmodule

// File: rtl/frame_bit_serializer.sv
module frame_bit_serializer #(
    parameter int ELEM_W  = 8,
    parameter int MIN_LEN = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_valid,
    output logic              load_ready,
    input  logic [ELEM_W-1:0] elem_lo,
    input  logic [ELEM_W-1:0] elem_hi,
    input  logic [4:0]        frame_len,
    input  logic              msb_first,
    input  logic              bit_tick,
    output logic              tx_bit,
    output logic              busy,
    output logic              done
);
    import fbs_pkg::*;

    localparam int DATA_W = 2 * ELEM_W;
    localparam int IDX_W  = $clog2(DATA_W);
    localparam int LEN_W  = 5;

    fbs_state_e state_q, state_d;

    logic             accept;
    logic             advance;
    logic             walk_last;
    logic             held_bit;
    logic [IDX_W-1:0] walk_idx;
    logic [IDX_W-1:0] plan_start;
    logic [LEN_W-1:0] plan_span;
    logic             plan_down;

    assign accept  = (state_q == ST_IDLE) && load_valid;
    assign advance = (state_q == ST_SHIFT) && bit_tick;

    fbs_order_plan #(
        .DATA_W (DATA_W),
        .ELEM_W (ELEM_W),
        .MIN_LEN(MIN_LEN),
        .LEN_W  (LEN_W),
        .IDX_W  (IDX_W)
    ) u_plan (
        .frame_len(frame_len),
        .msb_first(msb_first),
        .start_idx(plan_start),
        .span     (plan_span),
        .step_down(plan_down)
    );

    fbs_bit_walker #(
        .LEN_W(LEN_W),
        .IDX_W(IDX_W)
    ) u_walk (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .advance  (advance),
        .start_idx(plan_start),
        .span     (plan_span),
        .step_down(plan_down),
        .idx      (walk_idx),
        .last     (walk_last)
    );

    fbs_frame_hold #(
        .DATA_W(DATA_W),
        .ELEM_W(ELEM_W),
        .IDX_W (IDX_W)
    ) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (accept),
        .frame_in({elem_hi, elem_lo}),
        .sel     (walk_idx),
        .bit_out (held_bit)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (load_valid) state_d = ST_SHIFT;
            ST_SHIFT:  if (bit_tick && walk_last) state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        load_ready = 1'b0;
        busy       = 1'b0;
        done       = 1'b0;
        tx_bit     = 1'b1;
        unique case (state_q)
            ST_IDLE:   load_ready = 1'b1;
            ST_SHIFT:  begin busy = 1'b1; tx_bit = held_bit; end
            ST_FINISH: begin busy = 1'b1; done = 1'b1; end
            default:   load_ready = 1'b0;
        endcase
    end

    // R6: an accepted load starts a frame in the next cycle
    a_r6_load_starts: assert property (@(posedge clk) disable iff (!rst_n)
        (load_valid && load_ready) |=> (busy && !load_ready && !done));

    // R5: data bit holds while no tick arrives
    a_r5_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done && !bit_tick) |=> $stable(tx_bit));

    // R7: done lasts a single cycle and is followed by readiness
    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && load_ready && !busy));

    // R1: idle line is high
    a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> tx_bit);
endmodule

// File: tb/tb_frame_bit_serializer.sv
module tb_frame_bit_serializer;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       load_valid = 1'b0;
    logic       load_ready;
    logic [7:0] elem_lo = '0;
    logic [7:0] elem_hi = '0;
    logic [4:0] frame_len = 5'd8;
    logic       msb_first = 1'b0;
    logic       bit_tick = 1'b0;
    logic       tx_bit;
    logic       busy;
    logic       done;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    frame_bit_serializer dut (
        .clk(clk), .rst_n(rst_n),
        .load_valid(load_valid), .load_ready(load_ready),
        .elem_lo(elem_lo), .elem_hi(elem_hi),
        .frame_len(frame_len), .msb_first(msb_first),
        .bit_tick(bit_tick), .tx_bit(tx_bit),
        .busy(busy), .done(done)
    );

    task automatic chk(input logic act, input logic exp, input string tag, input string what);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0b expected=%0b", tag, what, act, exp);
        end
    endtask

    // Expected bit sequence built from the requirement text.
    task automatic build_expect(input logic [7:0] lo, input logic [7:0] hi,
                                input int len_in, input logic msb,
                                output logic seq [16], output int n);
        int len;
        len = (len_in < 4) ? 4 : ((len_in > 16) ? 16 : len_in);
        n = 0;
        for (int i = 0; i < 16; i++) seq[i] = 1'b0;
        if (!msb) begin
            for (int k = 0; k < len; k++) begin
                seq[n] = (k < 8) ? lo[k] : hi[k-8];
                n++;
            end
        end else if (len >= 10) begin
            for (int j = len - 9; j >= 0; j--) begin seq[n] = hi[j]; n++; end
            for (int j = 7; j >= 0; j--) begin seq[n] = lo[j]; n++; end
        end else begin
            int top;
            top = (len == 9) ? 7 : len - 1;
            for (int j = top; j >= 0; j--) begin seq[n] = lo[j]; n++; end
        end
    endtask

    // Sends one frame and checks every bit, the done pulse and the return to idle.
    task automatic send_frame(input logic [7:0] lo, input logic [7:0] hi,
                              input int len, input logic msb, input int gap,
                              input bit disturb, input string tag);
        logic seq [16];
        int n;
        build_expect(lo, hi, len, msb, seq, n);
        @(negedge clk);
        elem_lo = lo; elem_hi = hi; frame_len = 5'(len); msb_first = msb;
        load_valid = 1'b1;
        @(negedge clk);
        load_valid = 1'b0;
        chk(busy, 1'b1, "R6", {tag, " busy after load"});
        chk(load_ready, 1'b0, "R6", {tag, " ready low after load"});
        chk(tx_bit, seq[0], tag, "bit 0");
        for (int k = 1; k <= n; k++) begin
            if (disturb && k < n) begin
                elem_lo = ~lo; elem_hi = ~hi;
                frame_len = 5'(21 - len); msb_first = ~msb;
                load_valid = 1'b1;
            end
            for (int g = 0; g < gap; g++) @(negedge clk);
            if (gap > 0) chk(tx_bit, seq[k-1], "R5", {tag, " hold without tick"});
            if (k == n) load_valid = 1'b0;
            bit_tick = 1'b1;
            @(negedge clk);
            bit_tick = 1'b0;
            if (k < n) begin
                chk(tx_bit, seq[k], disturb ? "R8" : tag, $sformatf("bit %0d", k));
                chk(done, 1'b0, "R7", {tag, " no early done"});
            end else begin
                chk(done, 1'b1, "R7", {tag, " done after last tick"});
            end
        end
        load_valid = 1'b0;
        @(negedge clk);
        chk(done, 1'b0, "R7", {tag, " done one cycle"});
        chk(load_ready, 1'b1, "R7", {tag, " ready after done"});
        chk(busy, 1'b0, "R7", {tag, " idle after done"});
        chk(tx_bit, 1'b1, "R1", {tag, " idle line high"});
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(load_ready, 1'b1, "R1", "reset ready");
        chk(busy, 1'b0, "R1", "reset busy");
        chk(done, 1'b0, "R1", "reset done");
        chk(tx_bit, 1'b1, "R1", "reset line");
    endtask

    task automatic t_lsb_orders;
        send_frame(8'hA5, 8'h05, 11, 1'b0, 0, 1'b0, "R2");
        send_frame(8'h2D, 8'hFF, 6, 1'b0, 0, 1'b0, "R2");
    endtask

    task automatic t_msb_long;
        send_frame(8'h3C, 8'h06, 11, 1'b1, 3, 1'b0, "R3");
        send_frame(8'h96, 8'hC3, 16, 1'b1, 0, 1'b0, "R3");
    endtask

    task automatic t_msb_short;
        send_frame(8'h81, 8'h01, 9, 1'b1, 0, 1'b0, "R4");
        send_frame(8'h13, 8'hFF, 5, 1'b1, 1, 1'b0, "R4");
    endtask

    task automatic t_ignore_busy;
        send_frame(8'h5A, 8'h01, 9, 1'b0, 2, 1'b1, "R8");
    endtask

    task automatic t_clamp;
        send_frame(8'hF6, 8'hAA, 2, 1'b0, 0, 1'b0, "R9");
        send_frame(8'h69, 8'h4B, 20, 1'b1, 0, 1'b0, "R9");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        t_reset();
        t_lsb_orders();
        t_msb_long();
        t_msb_short();
        t_ignore_busy();
        t_clamp();
        repeat (2) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule